// File: doc/BRIEF.md
# Real-Mode Window Page Mapper

This block sits between a 16-bit CPU and a large RAM. It replaces the top four bits of the CPU's 20-bit real-mode address, which select one of sixteen 64 KB windows of the first megabyte, with a 10-bit page number held in a table of sixteen map registers. The result is a 26-bit RAM byte address. Any of the 1024 pages of a 64 MB RAM can therefore appear behind any window. Firmware uses this to flip between video pages, to bank a linear high-resolution frame buffer, and to reach memory above the first megabyte.

The CPU changes the table through 16-bit I/O writes to a block of sixteen consecutive ports, one port per window, and reads it back through the same ports. After reset the table follows a fixed layout. Low memory is mapped one to one. The two video windows show the first two pages of the 512 KB video area. The top four windows show the pages that follow the video area, which hold upper memory and the firmware region.

Top module: `seg_page_mapper`

## Requirements
- R1: After reset, window w maps to page w for w = 0 to 11 (windows 10 and 11 being the video windows at pages 10 and 11), and to page w + 6 for w = 12 to 15, so windows 12, 13, 14 and 15 map to pages 18, 19, 20 and 21.
- R2: `ram_addr` equals the 10-bit page of window `cpu_addr[19:16]` in bits 25:16, followed by `cpu_addr[15:0]` unchanged in bits 15:0. It is combinational from `cpu_addr`.
- R3: A write with `io_wr_en` high at port `IO_BASE + i` (i = 0 to 15, `IO_BASE` = 0x0080 by default) stores `io_wdata[9:0]` as the page of window i. The translation uses the new value from the cycle after the clock edge that takes the write, and the old value up to that edge.
- R4: Bits 15:10 of `io_wdata` are not stored.
- R5: `io_rdata` shows the stored page of window i, zero-extended to 16 bits, whenever `io_addr` is `IO_BASE + i`. It is combinational from `io_addr`.
- R6: For an `io_addr` outside `IO_BASE` to `IO_BASE + 15`, writes change no window and `io_rdata` is zero.
- R7: A write to one window leaves the other fifteen windows unchanged.
- R8: The synchronous active-low reset takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_addr | input | 20 | CPU real-mode physical address |
| ram_addr | output | 26 | Translated RAM byte address |
| io_addr | input | 16 | I/O port address for map register access |
| io_wr_en | input | 1 | I/O write strobe, one cycle per write |
| io_wdata | input | 16 | I/O write data |
| io_rdata | output | 16 | Readback of the addressed map register, zero outside the port block |

## Verification
The assertions assume that `io_addr`, `io_wdata` and `io_wr_en` are steady at each clock edge and that a write is a single-cycle strobe. They also assume that ports outside the sixteen-port block touch nothing. The readback and write-effect properties compare `io_addr` against its value one cycle earlier, so they only carry weight when a read follows a write to the same port. The stimulus keeps within these assumptions by driving every input at the falling edge. It mixes random ports just inside and just outside the block, data with random upper bits, and reads and translations aimed at the window just written.

// File: rtl/spm_pkg.sv
// Package: shared constants and the reset-layout function of the page mapper.
// Assumes the reset layout is low memory one to one, then video windows,
// then the pages that follow the video area.
package spm_pkg;

    // Default page of window w after reset.
    function automatic int unsigned spm_default_page(
        input int unsigned w,
        input int unsigned low_win,
        input int unsigned vid_win,
        input int unsigned vid_pages
    );
        if (w < low_win + vid_win)
            return w;
        return w + vid_pages - vid_win;
    endfunction

endpackage

// File: rtl/spm_io_decode.sv
// Module: decodes the I/O port address against the map register block.
// Assumes the block occupies NUM_WIN consecutive ports starting at IO_BASE.
module spm_io_decode #(
    parameter int IO_W    = 16,
    parameter int WIN_W   = 4,
    parameter int IO_BASE = 16'h0080,
    localparam int NUM_WIN = 1 << WIN_W
) (
    input  logic [IO_W-1:0]    io_addr,
    input  logic               io_wr_en,
    output logic               hit,
    output logic [WIN_W-1:0]   idx,
    output logic [NUM_WIN-1:0] wr_sel
);

    logic [IO_W-1:0] off;

    // Offset of the port from the block base and range test.
    always_comb begin
        off = io_addr - IO_W'(IO_BASE);
        hit = (off < IO_W'(NUM_WIN));
        idx = off[WIN_W-1:0];
    end

    // One write-select line per window.
    for (genvar i = 0; i < NUM_WIN; i++) begin : g_sel
        assign wr_sel[i] = io_wr_en && hit && (idx == WIN_W'(i));
    end

endmodule

// File: rtl/spm_map_table.sv
// Module: the table of per-window page registers with their reset layout.
// Assumes wr_sel is one-hot or zero; reset has priority over a write.
module spm_map_table #(
    parameter int PAGE_W    = 10,
    parameter int WIN_W     = 4,
    parameter int LOW_WIN   = 10,
    parameter int VID_WIN   = 2,
    parameter int VID_PAGES = 8,
    localparam int NUM_WIN  = 1 << WIN_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_WIN-1:0]              wr_sel,
    input  logic [PAGE_W-1:0]               wr_page,
    output logic [NUM_WIN-1:0][PAGE_W-1:0]  pages
);

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        localparam logic [PAGE_W-1:0] DEF_PAGE =
            PAGE_W'(spm_pkg::spm_default_page(i, LOW_WIN, VID_WIN, VID_PAGES));

        // Load the default at reset, the written page on a select.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pages[i] <= DEF_PAGE;
            else if (wr_sel[i])
                pages[i] <= wr_page;
        end
    end

endmodule

// File: rtl/spm_translate.sv
// Module: forms the RAM address from the window's page and the CPU offset.
// Assumes the window index is the top WIN_W bits of the CPU address.
module spm_translate #(
    parameter int PAGE_W   = 10,
    parameter int WIN_W    = 4,
    parameter int OFS_W    = 16,
    localparam int NUM_WIN = 1 << WIN_W,
    localparam int CPU_AW  = WIN_W + OFS_W,
    localparam int RAM_AW  = PAGE_W + OFS_W
) (
    input  logic [CPU_AW-1:0]               cpu_addr,
    input  logic [NUM_WIN-1:0][PAGE_W-1:0]  pages,
    output logic [RAM_AW-1:0]               ram_addr
);

    logic [WIN_W-1:0] win;

    // Select the window's page and append the untouched offset.
    always_comb begin
        win      = cpu_addr[CPU_AW-1:OFS_W];
        ram_addr = {pages[win], cpu_addr[OFS_W-1:0]};
    end

endmodule

// File: rtl/seg_page_mapper.sv
// Module: top of the real-mode window page mapper.
// Translates the CPU address through the page table and gives I/O access
// to the table. Assumes single-cycle I/O write strobes.
module seg_page_mapper #(
    parameter int CPU_AW    = 20,
    parameter int OFS_W     = 16,
    parameter int PAGE_W    = 10,
    parameter int IO_W      = 16,
    parameter int IO_BASE   = 16'h0080,
    parameter int LOW_WIN   = 10,
    parameter int VID_WIN   = 2,
    parameter int VID_PAGES = 8,
    localparam int WIN_W    = CPU_AW - OFS_W,
    localparam int NUM_WIN  = 1 << WIN_W,
    localparam int RAM_AW   = PAGE_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPU_AW-1:0] cpu_addr,
    output logic [RAM_AW-1:0] ram_addr,
    input  logic [IO_W-1:0]   io_addr,
    input  logic              io_wr_en,
    input  logic [IO_W-1:0]   io_wdata,
    output logic [IO_W-1:0]   io_rdata
);

    logic                            hit;
    logic [WIN_W-1:0]                idx;
    logic [NUM_WIN-1:0]              wr_sel;
    logic [NUM_WIN-1:0][PAGE_W-1:0]  pages;

    spm_io_decode #(
        .IO_W(IO_W), .WIN_W(WIN_W), .IO_BASE(IO_BASE)
    ) u_dec (
        .io_addr(io_addr), .io_wr_en(io_wr_en),
        .hit(hit), .idx(idx), .wr_sel(wr_sel)
    );

    spm_map_table #(
        .PAGE_W(PAGE_W), .WIN_W(WIN_W), .LOW_WIN(LOW_WIN),
        .VID_WIN(VID_WIN), .VID_PAGES(VID_PAGES)
    ) u_tab (
        .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel),
        .wr_page(io_wdata[PAGE_W-1:0]), .pages(pages)
    );

    spm_translate #(
        .PAGE_W(PAGE_W), .WIN_W(WIN_W), .OFS_W(OFS_W)
    ) u_xl (
        .cpu_addr(cpu_addr), .pages(pages), .ram_addr(ram_addr)
    );

    // Readback: zero-extended page of the addressed window, zero on a miss.
    always_comb begin
        io_rdata = '0;
        if (hit)
            io_rdata = IO_W'(pages[idx]);
    end

endmodule

// File: rtl/spm_checker.sv
// Module: properties of the page mapper, attached by bind.
// Assumes inputs are steady at each clock edge.
module spm_checker #(
    parameter int CPU_AW    = 20,
    parameter int OFS_W     = 16,
    parameter int PAGE_W    = 10,
    parameter int IO_W      = 16,
    parameter int IO_BASE   = 16'h0080,
    parameter int LOW_WIN   = 10,
    parameter int VID_WIN   = 2,
    parameter int VID_PAGES = 8,
    localparam int WIN_W    = CPU_AW - OFS_W,
    localparam int NUM_WIN  = 1 << WIN_W,
    localparam int RAM_AW   = PAGE_W + OFS_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CPU_AW-1:0] cpu_addr,
    input logic [RAM_AW-1:0] ram_addr,
    input logic [IO_W-1:0]   io_addr,
    input logic              io_wr_en,
    input logic [IO_W-1:0]   io_wdata,
    input logic [IO_W-1:0]   io_rdata
);

    logic [IO_W-1:0]  c_off;
    logic             c_hit;
    logic [WIN_W-1:0] c_win;
    logic             touched;
    logic [PAGE_W-1:0] c_def;

    // Independent port decode and reset-default lookup.
    always_comb begin
        c_off = io_addr - IO_W'(IO_BASE);
        c_hit = (c_off < IO_W'(NUM_WIN));
        c_win = cpu_addr[CPU_AW-1:OFS_W];
        c_def = PAGE_W'(spm_pkg::spm_default_page(32'(c_win), LOW_WIN, VID_WIN, VID_PAGES));
    end

    // Tracks whether any map register has been written since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            touched <= 1'b0;
        else if (io_wr_en && c_hit)
            touched <= 1'b1;
    end

    assert_reset_map_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !touched |-> ram_addr[RAM_AW-1:OFS_W] == c_def);

    assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ram_addr[OFS_W-1:0] == cpu_addr[OFS_W-1:0]);

    assert_write_effect_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(io_wr_en && c_hit) && c_win == $past(c_off[WIN_W-1:0]))
        |-> ram_addr[RAM_AW-1:OFS_W] == $past(io_wdata[PAGE_W-1:0]));

    assert_zero_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
        io_rdata[IO_W-1:PAGE_W] == '0);

    assert_readback_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(io_wr_en && c_hit) && io_addr == $past(io_addr))
        |-> io_rdata == IO_W'($past(io_wdata[PAGE_W-1:0])));

    assert_miss_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !c_hit |-> io_rdata == '0);

    assert_miss_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!(io_wr_en && c_hit)) && $stable(cpu_addr))
        |-> $stable(ram_addr));

endmodule

bind seg_page_mapper spm_checker #(
    .CPU_AW(CPU_AW), .OFS_W(OFS_W), .PAGE_W(PAGE_W), .IO_W(IO_W),
    .IO_BASE(IO_BASE), .LOW_WIN(LOW_WIN), .VID_WIN(VID_WIN), .VID_PAGES(VID_PAGES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .ram_addr(ram_addr),
    .io_addr(io_addr), .io_wr_en(io_wr_en), .io_wdata(io_wdata), .io_rdata(io_rdata)
);

// File: tb/seg_page_mapper_test.sv
// Bench: directed corners plus seeded random I/O writes, reads and translations.
module seg_page_mapper_test;

    localparam int BASE = 16'h0080;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] cpu_addr = '0;
    logic [25:0] ram_addr;
    logic [15:0] io_addr = '0;
    logic        io_wr_en = 1'b0;
    logic [15:0] io_wdata = '0;
    logic [15:0] io_rdata;

    int checks = 0;
    int failures = 0;
    logic [9:0] model [16];

    seg_page_mapper uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .ram_addr(ram_addr),
        .io_addr(io_addr), .io_wr_en(io_wr_en), .io_wdata(io_wdata), .io_rdata(io_rdata)
    );

    always #4 clk = ~clk;

    // Reset layout from R1.
    function automatic logic [9:0] def_page(input int w);
        return (w < 12) ? 10'(w) : 10'(w + 6);
    endfunction

    function automatic logic [25:0] exp_xlate(input logic [19:0] a);
        return {model[a[19:16]], a[15:0]};
    endfunction

    function automatic logic [15:0] exp_read(input logic [15:0] p);
        logic [15:0] off = p - 16'(BASE);
        return (off < 16) ? {6'b0, model[off[3:0]]} : 16'h0000;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int w = 0; w < 16; w++) model[w] = def_page(w);
    endtask

    task automatic chk_xlate(input logic [19:0] a, input string req);
        cpu_addr = a;
        #1;
        check(req, 32'(ram_addr), 32'(exp_xlate(a)));
    endtask

    task automatic chk_read(input logic [15:0] p, input string req);
        io_addr = p;
        #1;
        check(req, 32'(io_rdata), 32'(exp_read(p)));
    endtask

    // Drive a write at a falling edge; optionally confirm the old mapping holds before the edge.
    task automatic do_write(input logic [15:0] p, input logic [15:0] d, input bit pre);
        logic [15:0] off = p - 16'(BASE);
        @(negedge clk);
        io_addr = p; io_wdata = d; io_wr_en = 1'b1;
        if (pre && off < 16) chk_xlate({off[3:0], 16'h1234}, "R3 old value before edge");
        @(negedge clk);
        io_wr_en = 1'b0;
        if (off < 16) model[off[3:0]] = d[9:0];
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        int unsigned seed = 32'd20240611;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset layout, every window.
        for (int w = 0; w < 16; w++) chk_xlate({4'(w), 16'hBEEF}, "R1 reset map");
        for (int w = 0; w < 16; w++) chk_read(16'(BASE + w), "R1 reset readback");

        // R2: offset corners.
        chk_xlate(20'h00000, "R2 offset zero");
        chk_xlate(20'hFFFFF, "R2 offset top");

        // R3/R4: write with upper bits set to window 0xA, check next cycle.
        do_write(16'(BASE + 10), 16'hFC07, 1'b1);
        chk_xlate(20'hA0010, "R3 new page after edge");
        chk_read(16'(BASE + 10), "R4 upper bits dropped");

        // R7: neighbours of window 0xA untouched.
        chk_xlate(20'h9FFFF, "R7 neighbour below");
        chk_xlate(20'hB0000, "R7 neighbour above");

        // R6: ports just outside the block.
        do_write(16'(BASE - 1), 16'h03FF, 1'b0);
        do_write(16'(BASE + 16), 16'h03FF, 1'b0);
        chk_read(16'(BASE - 1), "R6 read below block");
        chk_read(16'(BASE + 16), "R6 read above block");
        for (int w = 0; w < 16; w++) chk_xlate({4'(w), 16'h0042}, "R6 table unchanged");

        // Highest page into the last window.
        do_write(16'(BASE + 15), 16'h03FF, 1'b1);
        chk_xlate(20'hFFFFE, "R3 top page");

        // Random mix.
        for (int n = 0; n < 400; n++) begin
            logic [15:0] p = 16'(BASE - 3 + int'($urandom_range(0, 21)));
            logic [15:0] d = 16'($urandom());
            logic [15:0] off = p - 16'(BASE);
            do_write(p, d, 1'b1);
            if (off < 16) chk_xlate({off[3:0], 16'($urandom())}, "R3 random write");
            chk_xlate(20'($urandom()), "R2 R7 random translate");
            chk_read(16'(BASE - 3 + int'($urandom_range(0, 21))), "R5 R6 random read");
        end

        // R8: reset with a simultaneous write restores defaults.
        @(negedge clk);
        rst_n = 1'b0; io_addr = 16'(BASE + 2); io_wdata = 16'h0155; io_wr_en = 1'b1;
        @(negedge clk);
        io_wr_en = 1'b0; rst_n = 1'b1;
        model_reset();
        for (int w = 0; w < 16; w++) chk_xlate({4'(w), 16'h7777}, "R8 reset beats write");
        chk_read(16'(BASE + 2), "R8 readback after reset");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule